// File: doc/BRIEF.md
# DMA Channel Link Controller

This block makes the linking decision for a running DMA channel each time that channel finishes one pass of its inner (minor) loop, which is one iteration of its outer (major) loop. It is given a one-cycle iteration-complete pulse together with the channel's current iteration count and two link settings. The inner-loop link setting is an enable and a target channel. The outer-loop link setting is also an enable and a target channel. From these the block decides whether the start flag of some channel has to be set. Setting that flag raises a new service request for the target channel. The target may be the running channel itself, so a channel can restart itself.

On every iteration except the last, only the inner-loop link setting counts. On the last iteration, the one that brings the count to zero, only the outer-loop link setting counts. In the same cycle the block reports the decremented iteration count, so the surrounding engine can write it back to the descriptor. Descriptor storage, address generation and arbitration belong to other blocks. All outputs are registered and appear one clock after the completion pulse.

Top module: `dma_link_ctrl`

## Requirements
- R1: While reset is held and after it is released with no completion pulse, `start_set_o`, `cnt_vld_o`, `start_ch_o` and `citer_o` are all zero.
- R2: A completion pulse with `citer_i` greater than 1 and `minor_en_i` = 1 makes `start_set_o` = 1 one clock later, with `start_ch_o` equal to the `minor_ch_i` value sampled with the pulse.
- R3: A completion pulse with `citer_i` of 1 or 0 (the last iteration) and `major_en_i` = 1 makes `start_set_o` = 1 one clock later, with `start_ch_o` equal to the sampled `major_ch_i`. The inner-loop link fields have no effect.
- R4: On the last iteration with `major_en_i` = 0, `start_set_o` stays 0 even when `minor_en_i` = 1.
- R5: On a non-last iteration with `minor_en_i` = 0, `start_set_o` stays 0 even when `major_en_i` = 1.
- R6: Every completion pulse makes `cnt_vld_o` = 1 one clock later, with `citer_o` equal to the sampled `citer_i` minus one. A count of 0 stays at 0. The count updates whether or not a link is issued.
- R7: `start_set_o` and `cnt_vld_o` are high only in the clock that directly follows a completion pulse. Back-to-back pulses give back-to-back results, and a pulse yields at most one start request.
- R8: If a count of 4 is fed back through `citer_o`, with inner link to channel 12 and outer link to channel 7, the block starts channel 12 three times and then channel 7 once, and the final count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iter_done_i | input | 1 | One-cycle pulse: a major-loop iteration of the running channel completed |
| citer_i | input | CNT_W | Current iteration count before this iteration is retired |
| minor_en_i | input | 1 | Inner-loop link enable |
| minor_ch_i | input | CH_W | Inner-loop link target channel |
| major_en_i | input | 1 | Outer-loop link enable |
| major_ch_i | input | CH_W | Outer-loop link target channel |
| start_set_o | output | 1 | One-cycle pulse: set the start flag of `start_ch_o` |
| start_ch_o | output | CH_W | Channel whose start flag is set |
| cnt_vld_o | output | 1 | One-cycle pulse: `citer_o` holds the updated count |
| citer_o | output | CNT_W | Iteration count after decrement |

## Verification
The bench builds the block with CNT_W = 6 and CH_W = 4. With these widths the all-ones count of 63 and the highest channel number, 15, can both be reached directly, as can the zero-count case that saturates at zero. The 16-channel target range is covered at both ends (channel 0 and channel 15). The small count width keeps the vector table short while the last-iteration boundary at counts 1 and 0 stays exercised.

// File: rtl/link_pkg.sv
package link_pkg;

  // Which link (if any) an iteration produces.
  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_MINOR = 2'd1,
    LK_MAJOR = 2'd2
  } link_kind_e;

endpackage

// File: rtl/link_iter_count.sv
// Retires one iteration: flags the last one and computes the next count.
module link_iter_count #(
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // The last iteration is the one that leaves the count at zero.
  function automatic logic f_is_last(input logic [CNT_W-1:0] c);
    return (c <= ONE);
  endfunction

  // Decrement, holding at zero.
  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : (c - ONE);
  endfunction

  always_comb begin
    last_o    = f_is_last(cnt_i);
    cnt_nxt_o = f_dec(cnt_i);
  end

endmodule

// File: rtl/link_select.sv
// Picks which link field governs this iteration and the resulting target.
module link_select
  import link_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            fire_i,
  input  logic            last_i,
  input  logic            minor_en_i,
  input  logic [CH_W-1:0] minor_ch_i,
  input  logic            major_en_i,
  input  logic [CH_W-1:0] major_ch_i,
  output link_kind_e      kind_o,
  output logic [CH_W-1:0] ch_o
);

  function automatic link_kind_e f_kind(input logic fire, input logic last,
                                        input logic men, input logic jen);
    if (!fire)      return LK_NONE;
    else if (last)  return jen ? LK_MAJOR : LK_NONE;
    else            return men ? LK_MINOR : LK_NONE;
  endfunction

  always_comb begin
    kind_o = f_kind(fire_i, last_i, minor_en_i, major_en_i);
    unique case (kind_o)
      LK_MINOR: ch_o = minor_ch_i;
      LK_MAJOR: ch_o = major_ch_i;
      default:  ch_o = '0;
    endcase
  end

endmodule

// File: rtl/dma_link_ctrl.sv
module dma_link_ctrl
  import link_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iter_done_i,
  input  logic [CNT_W-1:0] citer_i,
  input  logic             minor_en_i,
  input  logic [CH_W-1:0]  minor_ch_i,
  input  logic             major_en_i,
  input  logic [CH_W-1:0]  major_ch_i,
  output logic             start_set_o,
  output logic [CH_W-1:0]  start_ch_o,
  output logic             cnt_vld_o,
  output logic [CNT_W-1:0] citer_o
);

  localparam int NUM_CH = 1 << CH_W;

  // Named internal events, visible to the bound checker.
  logic             last_iter_w;
  logic [CNT_W-1:0] cnt_nxt_w;
  link_kind_e       link_kind_w;
  logic [CH_W-1:0]  link_ch_w;
  logic             link_req_w;

  link_iter_count #(.CNT_W(CNT_W)) u_cnt (
    .cnt_i     (citer_i),
    .cnt_nxt_o (cnt_nxt_w),
    .last_o    (last_iter_w)
  );

  link_select #(.CH_W(CH_W)) u_sel (
    .fire_i     (iter_done_i),
    .last_i     (last_iter_w),
    .minor_en_i (minor_en_i),
    .minor_ch_i (minor_ch_i),
    .major_en_i (major_en_i),
    .major_ch_i (major_ch_i),
    .kind_o     (link_kind_w),
    .ch_o       (link_ch_w)
  );

  assign link_req_w = (link_kind_w != LK_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_set_o <= 1'b0;
      start_ch_o  <= '0;
      cnt_vld_o   <= 1'b0;
      citer_o     <= '0;
    end else begin
      start_set_o <= link_req_w;
      cnt_vld_o   <= iter_done_i;
      if (link_req_w)  start_ch_o <= link_ch_w;
      if (iter_done_i) citer_o    <= cnt_nxt_w;
    end
  end

  initial begin
    if (NUM_CH < 2) $error("dma_link_ctrl: CH_W must be at least 1");
  end

endmodule

// File: rtl/dma_link_ctrl_chk.sv
module dma_link_ctrl_chk
  import link_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int CH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iter_done_i,
  input logic [CNT_W-1:0] citer_i,
  input logic             minor_en_i,
  input logic [CH_W-1:0]  minor_ch_i,
  input logic             major_en_i,
  input logic [CH_W-1:0]  major_ch_i,
  input logic             start_set_o,
  input logic [CH_W-1:0]  start_ch_o,
  input logic             cnt_vld_o,
  input logic [CNT_W-1:0] citer_o,
  input logic             last_iter_w,
  input logic             link_req_w
);

  function automatic logic [CNT_W-1:0] chk_dec(input logic [CNT_W-1:0] c);
    logic [CNT_W:0] wide;
    wide = {1'b0, c};
    return (wide == 0) ? '0 : CNT_W'(wide - 1);
  endfunction

  p_minor_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_i && citer_i > CNT_W'(1) && minor_en_i)
    |=> (start_set_o && start_ch_o == $past(minor_ch_i)));

  p_major_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_i && citer_i <= CNT_W'(1) && major_en_i)
    |=> (start_set_o && start_ch_o == $past(major_ch_i)));

  p_no_link_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_i && citer_i <= CNT_W'(1) && !major_en_i) |=> !start_set_o);

  p_no_link_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_i && citer_i > CNT_W'(1) && !minor_en_i) |=> !start_set_o);

  p_count_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iter_done_i |=> (cnt_vld_o && citer_o == chk_dec($past(citer_i))));

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !iter_done_i |=> (!start_set_o && !cnt_vld_o));

  p_req_needs_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_req_w |-> iter_done_i);

  p_last_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done_i && citer_i == CNT_W'(1)) |-> last_iter_w);

endmodule

bind dma_link_ctrl dma_link_ctrl_chk #(.CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iter_done_i (iter_done_i),
  .citer_i     (citer_i),
  .minor_en_i  (minor_en_i),
  .minor_ch_i  (minor_ch_i),
  .major_en_i  (major_en_i),
  .major_ch_i  (major_ch_i),
  .start_set_o (start_set_o),
  .start_ch_o  (start_ch_o),
  .cnt_vld_o   (cnt_vld_o),
  .citer_o     (citer_o),
  .last_iter_w (last_iter_w),
  .link_req_w  (link_req_w)
);

// File: tb/tb_dma_link_ctrl.sv
`timescale 1ns/1ps
module tb_dma_link_ctrl;

  localparam int CW = 6;
  localparam int HW = 4;

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          men;
    logic [HW-1:0] mch;
    logic          jen;
    logic [HW-1:0] jch;
    logic          exp_set;
    logic [HW-1:0] exp_ch;
    logic [CW-1:0] exp_cnt;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{6'd4,  1'b1, 4'hC, 1'b1, 4'h7, 1'b1, 4'hC, 6'd3,  4'd2}, // R2 mid, minor wins
    '{6'd1,  1'b1, 4'hC, 1'b1, 4'h7, 1'b1, 4'h7, 6'd0,  4'd3}, // R3 last, major wins
    '{6'd1,  1'b1, 4'hC, 1'b0, 4'h7, 1'b0, 4'h0, 6'd0,  4'd4}, // R4 last, major off
    '{6'd5,  1'b0, 4'h2, 1'b1, 4'h3, 1'b0, 4'h0, 6'd4,  4'd5}, // R5 mid, minor off
    '{6'd0,  1'b0, 4'h1, 1'b1, 4'h9, 1'b1, 4'h9, 6'd0,  4'd6}, // R6 zero holds, R3
    '{6'd63, 1'b1, 4'hF, 1'b0, 4'h0, 1'b1, 4'hF, 6'd62, 4'd6}, // R6 all-ones count
    '{6'd2,  1'b1, 4'h0, 1'b1, 4'hE, 1'b1, 4'h0, 6'd1,  4'd2}, // R2 channel 0
    '{6'd1,  1'b0, 4'h5, 1'b1, 4'hF, 1'b1, 4'hF, 6'd0,  4'd3}  // R3 channel 15
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iter_done_i = 1'b0;
  logic [CW-1:0] citer_i = '0;
  logic          minor_en_i = 1'b0;
  logic [HW-1:0] minor_ch_i = '0;
  logic          major_en_i = 1'b0;
  logic [HW-1:0] major_ch_i = '0;
  logic          start_set_o;
  logic [HW-1:0] start_ch_o;
  logic          cnt_vld_o;
  logic [CW-1:0] citer_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_link_ctrl #(.CNT_W(CW), .CH_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .iter_done_i(iter_done_i), .citer_i(citer_i),
    .minor_en_i(minor_en_i), .minor_ch_i(minor_ch_i),
    .major_en_i(major_en_i), .major_ch_i(major_ch_i),
    .start_set_o(start_set_o), .start_ch_o(start_ch_o),
    .cnt_vld_o(cnt_vld_o), .citer_o(citer_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one completion pulse at a falling edge; return after the next falling edge.
  task automatic pulse(input logic [CW-1:0] c, input logic men, input logic [HW-1:0] mch,
                       input logic jen, input logic [HW-1:0] jch);
    citer_i = c; minor_en_i = men; minor_ch_i = mch;
    major_en_i = jen; major_ch_i = jch; iter_done_i = 1'b1;
    @(negedge clk);
    iter_done_i = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 5000 && !finished) begin
        finished = 1;
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", wd, 5000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [CW-1:0] cnt;
    @(negedge clk);
    @(negedge clk);
    // R1: held in reset
    check("R1", "start_set in reset", int'(start_set_o), 0);
    check("R1", "cnt_vld in reset", int'(cnt_vld_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "start_ch after reset", int'(start_ch_o), 0);
    check("R1", "citer after reset", int'(citer_o), 0);
    check("R1", "start_set idle", int'(start_set_o), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      pulse(VECS[i].cnt, VECS[i].men, VECS[i].mch, VECS[i].jen, VECS[i].jch);
      check($sformatf("R%0d", VECS[i].req), "start_set", int'(start_set_o), int'(VECS[i].exp_set));
      if (VECS[i].exp_set)
        check($sformatf("R%0d", VECS[i].req), "start_ch", int'(start_ch_o), int'(VECS[i].exp_ch));
      check("R6", "cnt_vld", int'(cnt_vld_o), 1);
      check("R6", "citer", int'(citer_o), int'(VECS[i].exp_cnt));
      @(negedge clk);
      check("R7", "start_set drops", int'(start_set_o), 0);
      check("R7", "cnt_vld drops", int'(cnt_vld_o), 0);
    end

    // R7: back-to-back pulses
    citer_i = 6'd3; minor_en_i = 1'b1; minor_ch_i = 4'h5;
    major_en_i = 1'b1; major_ch_i = 4'h6; iter_done_i = 1'b1;
    @(negedge clk);
    citer_i = 6'd1;
    check("R7", "b2b first set", int'(start_set_o), 1);
    check("R7", "b2b first ch", int'(start_ch_o), 5);
    check("R7", "b2b first cnt", int'(citer_o), 2);
    @(negedge clk);
    iter_done_i = 1'b0;
    check("R7", "b2b second set", int'(start_set_o), 1);
    check("R7", "b2b second ch", int'(start_ch_o), 6);
    check("R7", "b2b second cnt", int'(citer_o), 0);
    @(negedge clk);
    check("R7", "b2b ends", int'(start_set_o), 0);

    // R7: inputs toggling without a pulse produce nothing
    citer_i = 6'd9; minor_en_i = 1'b1; major_en_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7", "no pulse no set", int'(start_set_o), 0);
    check("R7", "no pulse no vld", int'(cnt_vld_o), 0);

    // R8: full major loop, count fed back
    cnt = 6'd4;
    for (int k = 0; k < 4; k++) begin
      pulse(cnt, 1'b1, 4'hC, 1'b1, 4'h7);
      check("R8", "seq set", int'(start_set_o), 1);
      check("R8", "seq ch", int'(start_ch_o), (k < 3) ? 12 : 7);
      cnt = citer_o;
    end
    check("R8", "seq final count", int'(cnt), 0);

    // R1: reset mid-activity clears outputs
    pulse(6'd7, 1'b1, 4'hA, 1'b0, 4'h0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "reset clears set", int'(start_set_o), 0);
    check("R1", "reset clears count", int'(citer_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule